// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block merges four reset requests into one active-low system reset and a matching active-low reset output for other parts of the board. The requests are a power-good indication for two supplies, an external active-low reset pin, a reset command from the debug port, and a watchdog expiry pulse. While either supply is not good, reset is held. Every accepted request starts a fixed stretch interval of `STRETCH_CYC` cycles. A request that arrives during a stretch starts the interval again.

The external pin passes through a two-flop synchronizer and then a saturating counter that measures how long the pin stays low. A low pulse shorter than the programmed minimum width is dropped. A sticky cause register keeps one bit per source. Software clears its bits by writing ones, and a power-bad condition also clears it. When reset is released, the processor fetches from a fixed boot address.

Top module: `sys_rst_ctrl`

## Requirements
- R1: While `core_ok_i` or `io_ok_i` is low, `sys_rst_no` is 0. After both go high, `sys_rst_no` goes high on the (`STRETCH_CYC`+2)th rising edge, counting the first edge that samples both high as the first.
- R2: The external pin is low-active. It causes a reset only if it is sampled low on at least `min_width_i` consecutive rising edges (a value of 0 acts as 1). A shorter low pulse leaves `sys_rst_no` high and leaves `cause_o` unchanged.
- R3: Each accepted request holds `sys_rst_no` low for exactly `STRETCH_CYC` cycles. A second request accepted k cycles after the first, with k < `STRETCH_CYC`, makes the low time `STRETCH_CYC`+k.
- R4: `rst_pin_no` equals `sys_rst_no` on every cycle.
- R5: A high `dbg_rst_req_i` sampled on a rising edge makes `sys_rst_no` low right after that edge.
- R6: A high `wdt_expire_i` sampled on a rising edge makes `sys_rst_no` low right after that edge.
- R7: The `cause_o` bits are: bit0 power, bit1 pin, bit2 debug, bit3 watchdog. An accepted request sets its bit. The bits stay set through resets that do not come from power. A power-bad condition makes `cause_o` equal 4'b0001.
- R8: Writing a 1 to a bit of `cause_clr_i` for one cycle clears that cause bit. If a set and a clear reach the same bit in the same cycle, the set wins.
- R9: `boot_addr_o` equals `BOOT_ADDR` (default 32'h0000_0000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous reset of the controller's own flops, active low |
| core_ok_i | input | 1 | Core supply good |
| io_ok_i | input | 1 | I/O supply good |
| ext_rst_ni | input | 1 | External reset pin, asynchronous, active low |
| dbg_rst_req_i | input | 1 | Debug-port reset command pulse |
| wdt_expire_i | input | 1 | Watchdog expiry pulse |
| min_width_i | input | PIN_CNT_W | Minimum accepted low width of the pin, in cycles |
| cause_clr_i | input | 4 | Write-one-to-clear strobe for the cause bits |
| sys_rst_no | output | 1 | Internal system reset, active low |
| rst_pin_no | output | 1 | Board reset output, active low |
| cause_o | output | 4 | Sticky reset cause |
| boot_addr_o | output | 32 | First fetch address after reset |

## Verification
The hardest case to reach is a stretch that restarts partway through. A second source has to fire a known number of cycles after the first, while reset is still held, and the low episode must then grow by exactly that offset. The stimulus fires a debug pulse and then a watchdog pulse three cycles later, and the scoreboard expects one low episode of `STRETCH_CYC`+3. Pin pulses of exactly the minimum width and one cycle shorter probe the filter boundary, including a minimum width of 1. Clearing the cause register in the same cycle as a new request checks that the set wins.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;
  localparam int unsigned NUM_SRC = 4;

  typedef enum logic [1:0] {
    SRC_PWR = 2'd0,
    SRC_PIN = 2'd1,
    SRC_DBG = 2'd2,
    SRC_WDT = 2'd3
  } rst_src_e;

  typedef logic [NUM_SRC-1:0] cause_t;
endpackage

// File: rtl/rst_sync2.sv
module rst_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_ni,
  input  logic [CNT_W-1:0] min_width_i,
  output logic             req_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             pin_s;
  logic [CNT_W-1:0] low_cnt_q;
  logic [CNT_W-1:0] eff_min;
  logic             req_q;

  rst_sync2 #(.RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_ni),
    .q_o   (pin_s)
  );

  assign eff_min = (min_width_i == '0) ? CNT_ONE : min_width_i;

  // counter saturates so a long hold fires exactly once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
      req_q     <= 1'b0;
    end else begin
      req_q <= !pin_s && (low_cnt_q == eff_min - CNT_ONE);
      if (pin_s)                  low_cnt_q <= '0;
      else if (low_cnt_q != CNT_MAX) low_cnt_q <= low_cnt_q + CNT_ONE;
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int unsigned STRETCH_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic sys_rst_no,
  output logic pin_rst_no
);
  localparam int unsigned        SW     = $clog2(STRETCH_CYC + 1);
  localparam logic [SW-1:0]      ST_VAL = SW'(STRETCH_CYC);
  localparam logic [SW-1:0]      ONE    = SW'(1);

  logic [SW-1:0] cnt_q, cnt_d;
  logic          sys_n_q, pin_n_q;

  always_comb begin
    if (load_i)            cnt_d = ST_VAL;
    else if (cnt_q != '0)  cnt_d = cnt_q - ONE;
    else                   cnt_d = '0;
  end

  // two output flops on one next-state so the pad copy is a true register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= ST_VAL;
      sys_n_q <= 1'b0;
      pin_n_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      sys_n_q <= (cnt_d == '0);
      pin_n_q <= (cnt_d == '0);
    end
  end

  assign sys_rst_no = sys_n_q;
  assign pin_rst_no = pin_n_q;
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_ctrl_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pwr_bad_i,
  input  cause_t set_i,
  input  cause_t clr_i,
  output cause_t cause_o
);
  localparam cause_t PWR_ONLY = cause_t'(1) << SRC_PWR;

  cause_t cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cause_q <= PWR_ONLY;
    else if (pwr_bad_i) cause_q <= PWR_ONLY;
    else                cause_q <= (cause_q & ~clr_i) | set_i;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/sys_rst_ctrl.sv
module sys_rst_ctrl
  import rst_ctrl_pkg::*;
#(
  parameter int unsigned PIN_CNT_W   = 8,
  parameter int unsigned STRETCH_CYC = 16,
  parameter logic [31:0] BOOT_ADDR   = 32'h0000_0000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 core_ok_i,
  input  logic                 io_ok_i,
  input  logic                 ext_rst_ni,
  input  logic                 dbg_rst_req_i,
  input  logic                 wdt_expire_i,
  input  logic [PIN_CNT_W-1:0] min_width_i,
  input  logic [NUM_SRC-1:0]   cause_clr_i,
  output logic                 sys_rst_no,
  output logic                 rst_pin_no,
  output logic [NUM_SRC-1:0]   cause_o,
  output logic [31:0]          boot_addr_o
);
  logic   pwr_ok_s;
  logic   pin_req;
  cause_t src_req;

  rst_sync2 #(.RST_VAL(1'b0)) u_pwr_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (core_ok_i & io_ok_i),
    .q_o   (pwr_ok_s)
  );

  rst_pin_filter #(.CNT_W(PIN_CNT_W)) u_pin_filt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_ni     (ext_rst_ni),
    .min_width_i(min_width_i),
    .req_o      (pin_req)
  );

  always_comb begin
    src_req          = '0;
    src_req[SRC_PWR] = !pwr_ok_s;
    src_req[SRC_PIN] = pin_req;
    src_req[SRC_DBG] = dbg_rst_req_i;
    src_req[SRC_WDT] = wdt_expire_i;
  end

  rst_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (|src_req),
    .sys_rst_no(sys_rst_no),
    .pin_rst_no(rst_pin_no)
  );

  rst_cause_reg u_cause (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwr_bad_i(!pwr_ok_s),
    .set_i    (src_req),
    .clr_i    (cause_clr_i),
    .cause_o  (cause_o)
  );

  assign boot_addr_o = BOOT_ADDR;
endmodule

// File: rtl/rst_ctrl_chk.sv
module rst_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       core_ok_i,
  input logic       io_ok_i,
  input logic       dbg_rst_req_i,
  input logic       wdt_expire_i,
  input logic [3:0] cause_clr_i,
  input logic       sys_rst_no,
  input logic       rst_pin_no,
  input logic [3:0] cause_o
);
  AST_PAD_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pin_no == sys_rst_no); // R4
  AST_PWR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(core_ok_i && io_ok_i, 3) |-> !sys_rst_no); // R1
  AST_DBG_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_rst_req_i |=> !sys_rst_no); // R5
  AST_WDT_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_expire_i |=> !sys_rst_no); // R6
  AST_MIN_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_no) |=> !sys_rst_no); // R3
  AST_DBG_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_rst_req_i && core_ok_i && io_ok_i && $past(core_ok_i && io_ok_i)
     && $past(core_ok_i && io_ok_i, 2)) |=> cause_o[2]); // R7
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_expire_i && cause_clr_i[3] && core_ok_i && io_ok_i
     && $past(core_ok_i && io_ok_i) && $past(core_ok_i && io_ok_i, 2)) |=> cause_o[3]); // R8
endmodule

bind sys_rst_ctrl rst_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .core_ok_i    (core_ok_i),
  .io_ok_i      (io_ok_i),
  .dbg_rst_req_i(dbg_rst_req_i),
  .wdt_expire_i (wdt_expire_i),
  .cause_clr_i  (cause_clr_i),
  .sys_rst_no   (sys_rst_no),
  .rst_pin_no   (rst_pin_no),
  .cause_o      (cause_o)
);

// File: tb/tb_sys_rst_ctrl.sv
module tb_sys_rst_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int STRETCH    = 8;
  localparam int CW         = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          core_ok = 1'b0, io_ok = 1'b0;
  logic          ext_rst_n = 1'b1, dbg_req = 1'b0, wdt_exp = 1'b0;
  logic [CW-1:0] min_width = 8'd5;
  logic [3:0]    cause_clr = 4'b0;
  logic          sys_rst_n, pin_rst_n;
  logic [3:0]    cause;
  logic [31:0]   boot_addr;

  int checks = 0, failures = 0;
  int exp_q[$];
  string tag_q[$];
  int low_cnt = 0;
  bit mon_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_rst_ctrl #(.PIN_CNT_W(CW), .STRETCH_CYC(STRETCH)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .core_ok_i(core_ok), .io_ok_i(io_ok),
    .ext_rst_ni(ext_rst_n), .dbg_rst_req_i(dbg_req), .wdt_expire_i(wdt_exp),
    .min_width_i(min_width), .cause_clr_i(cause_clr),
    .sys_rst_no(sys_rst_n), .rst_pin_no(pin_rst_n),
    .cause_o(cause), .boot_addr_o(boot_addr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int dur, input string req);
    exp_q.push_back(dur);
    tag_q.push_back(req);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && (exp_q.size() != 0 || low_cnt != 0); i++) @(negedge clk);
    check(exp_q.size() == 0, "R3 episode missing", exp_q.size(), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic pin_pulse(input int edges);
    ext_rst_n = 1'b0;
    repeat (edges) @(negedge clk);
    ext_rst_n = 1'b1;
  endtask

  // monitor: measures each low episode and compares against the scoreboard
  always @(negedge clk) begin
    if (mon_en) begin
      if (pin_rst_n !== sys_rst_n) check(1'b0, "R4", pin_rst_n, sys_rst_n);
      if (!sys_rst_n) low_cnt++;
      else if (low_cnt != 0) begin
        if (exp_q.size() == 0) check(1'b0, "R2 unexpected reset", low_cnt, 0);
        else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(low_cnt == e, t, low_cnt, e);
          check(pin_rst_n == sys_rst_n, "R4", pin_rst_n, sys_rst_n);
        end
        low_cnt = 0;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(sys_rst_n == 1'b0, "R1 reset state", sys_rst_n, 0);
    check(pin_rst_n == 1'b0, "R4 reset state", pin_rst_n, 0);
    check(cause == 4'b0001, "R7 reset state", cause, 1);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    check(sys_rst_n == 1'b0, "R1 held while power bad", sys_rst_n, 0);

    // R1: power-up release timing
    core_ok = 1'b1;
    repeat (3) @(negedge clk);
    check(sys_rst_n == 1'b0, "R1 one supply good", sys_rst_n, 0);
    io_ok = 1'b1;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (sys_rst_n) break;
    end
    check(n == STRETCH + 2, "R1 power-up release", n, STRETCH + 2);
    check(boot_addr == 32'h0, "R9", boot_addr, 0);

    // R8: write-one-to-clear
    cause_clr = 4'b1111;
    @(negedge clk);
    cause_clr = 4'b0;
    check(cause == 4'b0000, "R8 clear", cause, 0);

    mon_en = 1'b1;
    // R5 debug
    push(STRETCH, "R5 debug stretch");
    dbg_req = 1'b1;
    @(negedge clk);
    dbg_req = 1'b0;
    check(sys_rst_n == 1'b0, "R5 debug asserts", sys_rst_n, 0);
    wait_idle();
    check(cause == 4'b0100, "R7 debug cause", cause, 4'b0100);

    // R6 watchdog
    push(STRETCH, "R6 watchdog stretch");
    wdt_exp = 1'b1;
    @(negedge clk);
    wdt_exp = 1'b0;
    check(sys_rst_n == 1'b0, "R6 watchdog asserts", sys_rst_n, 0);
    wait_idle();
    check(cause == 4'b1100, "R7 sticky cause", cause, 4'b1100);

    // R2 pin filter: one short of minimum is ignored
    min_width = 8'd5;
    pin_pulse(4);
    repeat (30) @(negedge clk);
    check(sys_rst_n == 1'b1, "R2 short pulse ignored", sys_rst_n, 1);
    check(cause == 4'b1100, "R2 cause unchanged", cause, 4'b1100);
    push(STRETCH, "R2 exact width accepted");
    pin_pulse(5);
    wait_idle();
    check(cause == 4'b1110, "R2 pin cause", cause, 4'b1110);

    // R2 zero width acts as one
    min_width = 8'd0;
    push(STRETCH, "R2 width zero as one");
    pin_pulse(1);
    wait_idle();

    // R3 restart: debug, then watchdog 3 cycles later
    push(STRETCH + 3, "R3 restart");
    dbg_req = 1'b1;
    @(negedge clk);
    dbg_req = 1'b0;
    repeat (2) @(negedge clk);
    wdt_exp = 1'b1;
    @(negedge clk);
    wdt_exp = 1'b0;
    wait_idle();

    // R8 set wins over clear
    push(STRETCH, "R8 set-wins stretch");
    cause_clr = 4'b1111;
    dbg_req = 1'b1;
    @(negedge clk);
    cause_clr = 4'b0;
    dbg_req = 1'b0;
    check(cause == 4'b0100, "R8 set wins", cause, 4'b0100);
    wait_idle();

    // R1/R7 power loss in operation
    mon_en = 1'b0;
    io_ok = 1'b0;
    repeat (3) @(negedge clk);
    check(sys_rst_n == 1'b0, "R1 power loss", sys_rst_n, 0);
    check(cause == 4'b0001, "R7 power cause", cause, 1);
    io_ok = 1'b1;
    repeat (STRETCH + 5) @(negedge clk);
    check(sys_rst_n == 1'b1, "R1 recovery", sys_rst_n, 1);
    check(boot_addr == 32'h0, "R9 after reset", boot_addr, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule